// File: doc/BRIEF.md
# Address Error Exception Sequencer

This controller sits inside a processor core and runs the entry sequence for an address-error exception. When the core flags a misaligned or illegal access, the sequencer accepts the error and waits until the faulting bus cycle has ended and the current instruction has retired. It then writes the return state to the stack through a 16-bit memory port, updates the condition and extended status registers, reads the handler address from a fixed vector slot, and hands that address to the program counter.

In the cycle it starts the sequence, it sends one-cycle stop pulses to an attached transfer controller and to a multichannel DMA controller. These pulses set each controller's error flag and clear the enable of every DMA channel. Any address error flagged while the sequence runs is ignored, so stacking faults cannot nest.

The controller is a one-hot state machine with eight states:

- `S_IDLE` moves to `S_WAIT_DONE` when an error arrives.
- `S_WAIT_DONE` moves to `S_PUSH_PC` when both the bus-done and instruction-done inputs are high.
- `S_PUSH_PC` moves to `S_PUSH_CCR` after two accepted writes.
- `S_PUSH_CCR` moves to `S_PUSH_EXR` after one accepted write.
- `S_PUSH_EXR` moves to `S_SET_MASK` after one accepted write.
- `S_SET_MASK` moves unconditionally to `S_READ_VEC`.
- `S_READ_VEC` moves to `S_LOAD_PC` after two accepted reads.
- `S_LOAD_PC` moves unconditionally to `S_IDLE`.

Top module: `aerr_seq`

## Requirements
- R1: In `S_IDLE`, a high `err_req` at a clock edge raises `busy` from the next cycle. The controller then stays in `S_WAIT_DONE`, with no memory request and no stop pulse, until `bus_done` and `insn_done` are high in the same cycle.
- R2: During the cycle in which `S_WAIT_DONE` is left, `xfer_halt`, `dma_err_flag` and every bit of `dma_en_clr` are high. All of them are low in every other cycle.
- R3: The registers are captured as the controller leaves `S_WAIT_DONE`. With the captured stack pointer SP, four writes follow in this order:
  - `pc_in[31:16]` to SP-2
  - `pc_in[15:0]` to SP-4
  - `{8'h00, ccr_in}` to SP-6
  - `{8'h00, exr_in}` to SP-8
- R4: While `mem_req` is high and `mem_ready` is low, the controller does not advance, and `mem_addr`, `mem_we` and (for writes) `mem_wdata` hold their values.
- R5: In the cycle `regs_wr` is high, `ccr_out` equals the captured CCR with bit 7 (the interrupt mask) set and all other bits, including bit 6, unchanged.
- R6: With `icm2`=1 (mode 2) captured, `exr_out` is the captured EXR with bit 7 (trace) cleared, bits 2:0 (level) set to 7, and bits 6:3 kept. With `icm2`=0, `exr_out` equals the captured EXR.
- R7: After the pushes, two reads fetch the high word at `VEC_ADDR` and then the low word at `VEC_ADDR`+2. `pc_load` then pulses for one cycle with `pc_new` = {high, low}, and `busy` is low in the following cycle.
- R8: An `err_req` that arrives while `busy` is high is ignored. It causes no stop pulse, no restart and no extra memory access, and the controller returns to idle.
- R9: In the `regs_wr` cycle, `sp_out` equals the captured SP minus 8.
- R10: An odd stack pointer still yields exactly four writes, two reads and the vector load. The pushed contents are not constrained.
- R11: While reset is asserted and just after it is released, `busy`, `mem_req`, `regs_wr`, `pc_load` and all stop outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_req | input | 1 | Address error flagged by the core |
| bus_done | input | 1 | Faulting bus cycle has ended |
| insn_done | input | 1 | Current instruction has completed |
| icm2 | input | 1 | 1 = interrupt control mode 2, 0 = mode 0 |
| sp_in | input | AW | Current stack pointer |
| pc_in | input | 2*DW | Return program counter |
| ccr_in | input | 8 | Current condition register |
| exr_in | input | 8 | Current extended status register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted at this edge |
| busy | output | 1 | Sequence in progress |
| xfer_halt | output | 1 | Sets the transfer controller error flag |
| dma_err_flag | output | 1 | Sets the DMA controller error flag |
| dma_en_clr | output | NCH | Per-channel DMA enable clear |
| regs_wr | output | 1 | Write ccr_out, exr_out, sp_out into the core |
| sp_out | output | AW | Stack pointer after pushes |
| ccr_out | output | 8 | Updated condition register |
| exr_out | output | 8 | Updated extended status register |
| pc_load | output | 1 | Load pc_new into the program counter |
| pc_new | output | 2*DW | Handler address |

## Verification
The embedded assertions check several properties on every cycle:
- the state is one-hot;
- the request stays stable while a memory access is stalled;
- the stop pulses last a single cycle and are followed immediately by the first write;
- the mask bit is set whenever `regs_wr` fires;
- `busy` clears after `pc_load`;
- `S_WAIT_DONE` cannot be re-entered while a sequence is running.

Some behaviours can only be shown by the bench scenarios, because they depend on values captured at entry:
- the exact stack addresses and the push order;
- the preserved UI bit;
- the mode-dependent EXR result;
- the final stack pointer;
- the assembled handler address;
- the behaviour of an odd stack pointer and of errors raised mid-sequence.

// File: rtl/aerr_pkg.sv
package aerr_pkg;

    typedef enum logic [7:0] {
        S_IDLE     = 8'b0000_0001,
        S_WAIT_DONE= 8'b0000_0010,
        S_PUSH_PC  = 8'b0000_0100,
        S_PUSH_CCR = 8'b0000_1000,
        S_PUSH_EXR = 8'b0001_0000,
        S_SET_MASK = 8'b0010_0000,
        S_READ_VEC = 8'b0100_0000,
        S_LOAD_PC  = 8'b1000_0000
    } aerr_state_t;

    localparam int CCR_MASK_BIT = 7;
    localparam int EXR_TRACE_BIT = 7;

endpackage

// File: rtl/aerr_ctrl.sv
module aerr_ctrl
    import aerr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        err_req,
    input  logic        bus_done,
    input  logic        insn_done,
    input  logic        mem_ready,
    output aerr_state_t state,
    output logic        wsel,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic        cap,
    output logic        regs_wr,
    output logic        pc_load
);

    aerr_state_t state_nx;
    logic        two_word;
    logic        step_ok;

    assign two_word = (state == S_PUSH_PC) || (state == S_READ_VEC);
    assign step_ok  = mem_req && mem_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            wsel  <= 1'b0;
        end else begin
            state <= state_nx;
            if (two_word && step_ok) begin
                wsel <= ~wsel;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (err_req) state_nx = S_WAIT_DONE;
            S_WAIT_DONE: if (bus_done && insn_done) state_nx = S_PUSH_PC;
            S_PUSH_PC:   if (step_ok && wsel) state_nx = S_PUSH_CCR;
            S_PUSH_CCR:  if (step_ok) state_nx = S_PUSH_EXR;
            S_PUSH_EXR:  if (step_ok) state_nx = S_SET_MASK;
            S_SET_MASK:  state_nx = S_READ_VEC;
            S_READ_VEC:  if (step_ok && wsel) state_nx = S_LOAD_PC;
            S_LOAD_PC:   state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy    = 1'b1;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        cap     = 1'b0;
        regs_wr = 1'b0;
        pc_load = 1'b0;
        unique case (state)
            S_IDLE:      busy = 1'b0;
            S_WAIT_DONE: cap = bus_done && insn_done;
            S_PUSH_PC,
            S_PUSH_CCR,
            S_PUSH_EXR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_SET_MASK:  regs_wr = 1'b1;
            S_READ_VEC:  mem_req = 1'b1;
            S_LOAD_PC:   pc_load = 1'b1;
            default:     busy = 1'b0;
        endcase
    end

    // R1
    state_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state) == 1);

    // R8
    no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && state != S_WAIT_DONE) |=> (state != S_WAIT_DONE));

endmodule

// File: rtl/aerr_dp.sv
module aerr_dp
    import aerr_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          DW       = 16,
    parameter logic [AW-1:0] VEC_ADDR = 32'h0000_0040,
    localparam int         PCW      = 2 * DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap,
    input  logic           fire,
    input  aerr_state_t    state,
    input  logic           wsel,
    input  logic [AW-1:0]  sp_in,
    input  logic [PCW-1:0] pc_in,
    input  logic [7:0]     ccr_in,
    input  logic [7:0]     exr_in,
    input  logic           icm2,
    input  logic [DW-1:0]  mem_rdata,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic [AW-1:0]  sp_out,
    output logic [7:0]     ccr_out,
    output logic [7:0]     exr_out,
    output logic [PCW-1:0] pc_new
);

    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    logic [AW-1:0]  sp_r;
    logic [PCW-1:0] pc_r;
    logic [PCW-1:0] vec_r;
    logic [7:0]     ccr_r;
    logic [7:0]     exr_r;
    logic           mode_r;
    logic           pushing;

    assign pushing = (state == S_PUSH_PC) || (state == S_PUSH_CCR) ||
                     (state == S_PUSH_EXR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_r   <= '0;
            pc_r   <= '0;
            vec_r  <= '0;
            ccr_r  <= '0;
            exr_r  <= '0;
            mode_r <= 1'b0;
        end else if (cap) begin
            sp_r   <= sp_in;
            pc_r   <= pc_in;
            ccr_r  <= ccr_in;
            exr_r  <= exr_in;
            mode_r <= icm2;
        end else if (fire) begin
            if (pushing) begin
                sp_r <= sp_r - STEP;
            end else if (state == S_READ_VEC) begin
                if (!wsel) vec_r[PCW-1:DW] <= mem_rdata;
                else       vec_r[DW-1:0]   <= mem_rdata;
            end
        end
    end

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            S_PUSH_PC: begin
                mem_addr  = sp_r - STEP;
                mem_wdata = wsel ? pc_r[DW-1:0] : pc_r[PCW-1:DW];
            end
            S_PUSH_CCR: begin
                mem_addr  = sp_r - STEP;
                mem_wdata = DW'(ccr_r);
            end
            S_PUSH_EXR: begin
                mem_addr  = sp_r - STEP;
                mem_wdata = DW'(exr_r);
            end
            S_READ_VEC:  mem_addr = wsel ? (VEC_ADDR + STEP) : VEC_ADDR;
            default: begin
                mem_addr  = '0;
                mem_wdata = '0;
            end
        endcase
    end

    always_comb begin
        ccr_out = ccr_r;
        ccr_out[CCR_MASK_BIT] = 1'b1;
        exr_out = exr_r;
        if (mode_r) begin
            exr_out[EXR_TRACE_BIT] = 1'b0;
            exr_out[2:0] = 3'b111;
        end
    end

    assign sp_out = sp_r;
    assign pc_new = vec_r;

endmodule

// File: rtl/aerr_seq.sv
module aerr_seq
    import aerr_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            DW       = 16,
    parameter int            NCH      = 4,
    parameter logic [AW-1:0] VEC_ADDR = 32'h0000_0040,
    localparam int           PCW      = 2 * DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           err_req,
    input  logic           bus_done,
    input  logic           insn_done,
    input  logic           icm2,
    input  logic [AW-1:0]  sp_in,
    input  logic [PCW-1:0] pc_in,
    input  logic [7:0]     ccr_in,
    input  logic [7:0]     exr_in,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ready,
    output logic           busy,
    output logic           xfer_halt,
    output logic           dma_err_flag,
    output logic [NCH-1:0] dma_en_clr,
    output logic           regs_wr,
    output logic [AW-1:0]  sp_out,
    output logic [7:0]     ccr_out,
    output logic [7:0]     exr_out,
    output logic           pc_load,
    output logic [PCW-1:0] pc_new
);

    aerr_state_t state;
    logic        wsel;
    logic        cap;

    aerr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_req   (err_req),
        .bus_done  (bus_done),
        .insn_done (insn_done),
        .mem_ready (mem_ready),
        .state     (state),
        .wsel      (wsel),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .cap       (cap),
        .regs_wr   (regs_wr),
        .pc_load   (pc_load)
    );

    aerr_dp #(.AW(AW), .DW(DW), .VEC_ADDR(VEC_ADDR)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .fire      (mem_req && mem_ready),
        .state     (state),
        .wsel      (wsel),
        .sp_in     (sp_in),
        .pc_in     (pc_in),
        .ccr_in    (ccr_in),
        .exr_in    (exr_in),
        .icm2      (icm2),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sp_out    (sp_out),
        .ccr_out   (ccr_out),
        .exr_out   (exr_out),
        .pc_new    (pc_new)
    );

    assign xfer_halt    = cap;
    assign dma_err_flag = cap;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan_stop
        assign dma_en_clr[ch] = cap;
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
            $stable(mem_we) && (!mem_we || $stable(mem_wdata))));

    // R2
    halt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_err_flag |=> !dma_err_flag);

    // R3
    halt_then_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_halt |=> (mem_req && mem_we));

    // R5
    ccr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_wr |-> ccr_out[CCR_MASK_BIT]);

    // R7
    idle_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);

endmodule

// File: tb/aerr_seq_tb.sv
`timescale 1ns/1ps
module aerr_seq_tb_top;

    localparam logic [31:0] VEC = 32'h0000_0040;

    typedef struct packed {
        logic [31:0] sp;
        logic [31:0] pc;
        logic [7:0]  ccr;
        logic [7:0]  exr;
        logic        m2;
        logic [15:0] vh;
        logic [15:0] vl;
        logic [3:0]  lat;
    } vec_t;

    localparam vec_t CASES [5] = '{
        '{32'h0000_1000, 32'h0000_1234, 8'h00, 8'h00, 1'b0, 16'h0000, 16'h2000, 4'd0},
        '{32'h0000_FFF0, 32'hABCD_0102, 8'h3F, 8'h85, 1'b1, 16'h0001, 16'h8000, 4'd1},
        '{32'h0010_0000, 32'hFFFF_FFFE, 8'h40, 8'h80, 1'b0, 16'h1234, 16'h5678, 4'd2},
        '{32'h0000_0008, 32'h0000_0000, 8'hFF, 8'hFF, 1'b1, 16'hFFFF, 16'hFFFE, 4'd0},
        '{32'h2000_0002, 32'h5555_AAAA, 8'h00, 8'h7A, 1'b1, 16'h00C0, 16'h0100, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_req = 1'b0, bus_done = 1'b0, insn_done = 1'b0, icm2 = 1'b0;
    logic [31:0] sp_in = '0, pc_in = '0;
    logic [7:0]  ccr_in = '0, exr_in = '0;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        mem_req, mem_we, busy, xfer_halt, dma_err_flag, regs_wr, pc_load;
    logic [31:0] mem_addr, sp_out, pc_new;
    logic [15:0] mem_wdata;
    logic [3:0]  dma_en_clr;
    logic [7:0]  ccr_out, exr_out;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    aerr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .err_req(err_req), .bus_done(bus_done),
        .insn_done(insn_done), .icm2(icm2), .sp_in(sp_in), .pc_in(pc_in),
        .ccr_in(ccr_in), .exr_in(exr_in), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .xfer_halt(xfer_halt),
        .dma_err_flag(dma_err_flag), .dma_en_clr(dma_en_clr), .regs_wr(regs_wr),
        .sp_out(sp_out), .ccr_out(ccr_out), .exr_out(exr_out),
        .pc_load(pc_load), .pc_new(pc_new)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic quiet();
        return !xfer_halt && !dma_err_flag && dma_en_clr == '0;
    endfunction

    task automatic run_exc(input vec_t v, input bit partial, input bit reerr, input bit odd);
        logic [31:0] wa [4];
        logic [15:0] wd [4];
        logic [31:0] ra [2];
        logic [31:0] st_addr;
        logic [15:0] st_data;
        logic [7:0]  g_ccr, g_exr;
        logic [31:0] g_sp, g_pc;
        logic [7:0]  e_exr;
        int nw, nr, wcnt, extra, nregs;
        bit stalled, st_we, hold_bad, fin;
        nw = 0; nr = 0; wcnt = 0; extra = 0; nregs = 0;
        stalled = 0; hold_bad = 0; fin = 0; st_we = 0;
        st_addr = '0; st_data = '0; g_ccr = '0; g_exr = '0; g_sp = '0; g_pc = '0;
        @(negedge clk);
        sp_in = v.sp; pc_in = v.pc; ccr_in = v.ccr; exr_in = v.exr; icm2 = v.m2;
        err_req = 1'b1;
        @(negedge clk);
        err_req = 1'b0;
        chk(busy == 1'b1, "R1 busy after accept", 64'(busy), 64'd1);
        repeat (2) @(negedge clk);
        chk(!mem_req && quiet(), "R1 wait before done", 64'(mem_req), 64'd0);
        if (partial) begin
            bus_done = 1'b1;
            #1;
            chk(!mem_req && quiet(), "R1 bus_done alone", 64'(xfer_halt), 64'd0);
            @(negedge clk);
            chk(!mem_req && busy, "R1 still waiting", 64'(mem_req), 64'd0);
        end
        bus_done = 1'b1; insn_done = 1'b1;
        #1;
        chk(xfer_halt && dma_err_flag && dma_en_clr == 4'hF, "R2 stop pulses",
            64'({xfer_halt, dma_err_flag, dma_en_clr}), 64'h3F);
        @(negedge clk);
        bus_done = 1'b0; insn_done = 1'b0;
        chk(quiet(), "R2 pulse ends", 64'({xfer_halt, dma_err_flag, dma_en_clr}), 64'h0);
        if (reerr) err_req = 1'b1;
        for (int cyc = 0; cyc < 80 && !fin; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (!quiet()) extra++;
            if (mem_req) begin
                if (stalled && (mem_addr !== st_addr || mem_we !== st_we ||
                                (mem_we && mem_wdata !== st_data)))
                    hold_bad = 1;
                if (wcnt < int'(v.lat)) begin
                    mem_ready = 1'b0; wcnt++; stalled = 1;
                    st_addr = mem_addr; st_we = mem_we; st_data = mem_wdata;
                end else begin
                    mem_ready = 1'b1; wcnt = 0; stalled = 0;
                    if (mem_we) begin
                        if (nw < 4) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; end
                        nw++;
                    end else begin
                        if (nr < 2) ra[nr] = mem_addr;
                        mem_rdata = (nr == 0) ? v.vh : v.vl;
                        nr++;
                    end
                end
            end else begin
                mem_ready = 1'b0;
            end
            if (regs_wr) begin
                g_ccr = ccr_out; g_exr = exr_out; g_sp = sp_out; nregs++;
            end
            if (pc_load) begin
                g_pc = pc_new; fin = 1; err_req = 1'b0; mem_ready = 1'b0;
            end
        end
        chk(fin, "R7 pc_load seen", 64'(fin), 64'd1);
        @(negedge clk);
        chk(!busy, "R7 busy drops", 64'(busy), 64'd0);
        chk(nw == 4 && nr == 2 && nregs == 1, odd ? "R10 access count" : "R3 access count",
            64'({nw[7:0], nr[7:0], nregs[7:0]}), 64'h040201);
        chk(!hold_bad, "R4 stalled request stable", 64'(hold_bad), 64'd0);
        chk(extra == 0, reerr ? "R8 no pulse mid-sequence" : "R2 no pulse mid-sequence",
            64'(extra), 64'd0);
        chk(nr == 2 && ra[0] == VEC && ra[1] == VEC + 2, "R7 vector addresses",
            64'({ra[0], ra[1]}), 64'({VEC, VEC + 32'd2}));
        chk(g_pc == {v.vh, v.vl}, odd ? "R10 vector load" : "R7 handler address",
            64'(g_pc), 64'({v.vh, v.vl}));
        chk(g_ccr == (v.ccr | 8'h80), "R5 ccr mask/UI kept", 64'(g_ccr), 64'(v.ccr | 8'h80));
        e_exr = v.m2 ? ((v.exr & 8'h78) | 8'h07) : v.exr;
        chk(g_exr == e_exr, v.m2 ? "R6 exr mode2" : "R6 exr mode0", 64'(g_exr), 64'(e_exr));
        chk(g_sp == v.sp - 32'd8, "R9 final sp", 64'(g_sp), 64'(v.sp - 32'd8));
        if (!odd && nw == 4) begin
            chk(wa[0] == v.sp - 2 && wa[1] == v.sp - 4 && wa[2] == v.sp - 6 &&
                wa[3] == v.sp - 8, "R3 push addresses", 64'({wa[0], wa[3]}),
                64'({v.sp - 32'd2, v.sp - 32'd8}));
            chk(wd[0] == v.pc[31:16] && wd[1] == v.pc[15:0] &&
                wd[2] == {8'h00, v.ccr} && wd[3] == {8'h00, v.exr}, "R3 push data",
                64'({wd[0], wd[1], wd[2], wd[3]}),
                64'({v.pc, 8'h00, v.ccr, 8'h00, v.exr}));
        end
        if (reerr) begin
            repeat (3) @(negedge clk);
            chk(!busy && !mem_req && quiet(), "R8 no restart", 64'(busy), 64'd0);
        end
    endtask

    initial begin
        #50000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        vec_t odd_v;
        err_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !regs_wr && !pc_load && quiet(), "R11 in reset",
            64'({busy, mem_req, regs_wr, pc_load}), 64'd0);
        err_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req && quiet(), "R11 after reset", 64'(busy), 64'd0);

        for (int i = 0; i < 5; i++) begin
            run_exc(CASES[i], 1'b0, 1'b0, 1'b0);
        end

        run_exc(CASES[1], 1'b1, 1'b0, 1'b0);
        run_exc(CASES[2], 1'b0, 1'b1, 1'b0);
        odd_v = CASES[0];
        odd_v.sp = 32'h0000_1001;
        odd_v.lat = 4'd1;
        run_exc(odd_v, 1'b0, 1'b0, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule